// File: doc/BRIEF.md
# Flash Identifier and Query Read Multiplexer

This block is the read path of a flash memory device. Each cycle it looks at the current read mode and the byte address, and picks one of several sources for the byte that goes back to the bus. The sources are the memory array, a small constant table of identifier and capability codes, the per-block lock bits, the main status register and the extended status register. Address bit 0 plays no part in the choice. The block works on the halfword index, which is the address shifted right by one. It also drives that index out so that the array can fetch the matching byte.

The address is folded in a different way for each mode. Identifier mode repeats a four-entry window. Query mode repeats a 128-entry window, reads as zero in a sixteen-entry hole, and reports a lock bit at one fixed index. Status modes ignore the address. The chosen byte is registered, so it appears one clock after the mode and address are presented.

Top module: `flash_id_read_mux`

## Requirements
- R1: While reset is asserted, and after it until the first active edge, `rd_data` is 0x00.
- R2: `rd_data` is registered. After the inputs change it keeps its old value until the next rising clock edge, and then shows the value chosen from the inputs sampled at that edge. `arr_idx` is combinational and equals `addr >> 1`.
- R3: Array mode (`rd_mode` = 0) returns `arr_data`.
- R4: Identifier mode (`rd_mode` = 1) with `idx[1:0]` not equal to 2 returns table entry `idx & 3`: 0xB0 for 0, 0xD0 for 1 and 0x02 for 3.
- R5: Identifier mode with `idx[1:0]` = 2 returns the lock bit of block `idx >> 15` in bit 0. Bit 1 is set when `idx & 0x1F` is 4 or more. All other bits are 0.
- R6: Query mode (`rd_mode` = 2) with `idx & 0x7F` = 2 returns the lock bit of block `idx >> 15` in bit 0, with all other bits 0.
- R7: Query mode with `idx & 0x7F` in 0x40 to 0x4F returns 0x00.
- R8: Query mode at any other index returns table entry `idx & 0x3F`. The table holds 0x51, 0x52, 0x59 at 0x10 to 0x12, 0x05 at 0x2A, 0x1F, 0x00, 0x00, 0x01 at 0x2D to 0x30, and 0x50, 0x52, 0x49 at 0x31 to 0x33.
- R9: Status mode (`rd_mode` = 3) returns `status` for every address.
- R10: Extended-status mode (`rd_mode` = 4) returns `ext_status` for every address.
- R11: Mode codes 5, 6 and 7 return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_mode | input | 3 | Read mode code |
| addr | input | ADDR_W (21) | Byte address; bit 0 is ignored |
| status | input | 8 | Main status register value |
| ext_status | input | 8 | Extended status register value |
| lock_bits | input | 2**(ADDR_W-1-BLK_SHIFT) (32) | One lock bit per block |
| arr_data | input | 8 | Array byte for the index on `arr_idx` |
| arr_idx | output | ADDR_W-1 (20) | Halfword index sent to the array |
| rd_data | output | 8 | Registered read data |

## Verification
Two lookups can meet in one cycle. The first is a lock-bit report, whose result depends on the high block bits of the index. The second is a table read or address fold, whose result depends on the low bits. Every index whose low bits select the lock window must therefore take the block number from the top bits and the rest of the byte from the low bits. Random addresses mix arbitrary block numbers with low bits forced into the lock windows and into the zero hole. The lock vector and the status values are redrawn every cycle, so a stale or wrongly sliced bit shows up as a mismatch against the bench's own model of that cycle's inputs.

// File: rtl/fr_pkg.sv
package fr_pkg;
  localparam logic [2:0] MODE_ARRAY = 3'd0;
  localparam logic [2:0] MODE_IDENT = 3'd1;
  localparam logic [2:0] MODE_QUERY = 3'd2;
  localparam logic [2:0] MODE_STAT  = 3'd3;
  localparam logic [2:0] MODE_XSTAT = 3'd4;

  localparam logic [1:0] LOCK_SLOT  = 2'd2;

  // constant identifier / capability table, 64 entries, unlisted = 0
  function automatic logic [7:0] cap_table(input logic [5:0] ent);
    logic [7:0] v;
    case (ent)
      6'h00: v = 8'hB0;  6'h01: v = 8'hD0;  6'h03: v = 8'h02;
      6'h10: v = 8'h51;  6'h11: v = 8'h52;  6'h12: v = 8'h59;
      6'h13: v = 8'h01;  6'h15: v = 8'h31;
      6'h1B: v = 8'h30;  6'h1C: v = 8'h55;  6'h1D: v = 8'h30;
      6'h1E: v = 8'h55;  6'h1F: v = 8'h03;  6'h20: v = 8'h06;
      6'h21: v = 8'h0A;  6'h22: v = 8'h0F;
      6'h23, 6'h24, 6'h25, 6'h26: v = 8'h04;
      6'h27: v = 8'h15;  6'h28: v = 8'h02;  6'h2A: v = 8'h05;
      6'h2C: v = 8'h01;  6'h2D: v = 8'h1F;  6'h30: v = 8'h01;
      6'h31: v = 8'h50;  6'h32: v = 8'h52;  6'h33: v = 8'h49;
      6'h34: v = 8'h31;  6'h35: v = 8'h30;  6'h36: v = 8'h0F;
      6'h3A: v = 8'h01;  6'h3B: v = 8'h03;
      6'h3D: v = 8'h50;  6'h3E: v = 8'h50;
      default: v = 8'h00;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/fr_cap_rom.sv
module fr_cap_rom (
  input  logic [5:0] ent,
  output logic [7:0] val
);
  import fr_pkg::*;

  always_comb begin
    val = cap_table(ent);
  end
endmodule

// File: rtl/fr_fold.sv
module fr_fold (
  input  logic [2:0] mode,
  input  logic [6:0] low7,
  input  logic       lock_bit,
  input  logic [7:0] status,
  input  logic [7:0] ext_status,
  input  logic [7:0] arr_data,
  output logic [7:0] sel_data
);
  import fr_pkg::*;

  logic [5:0] rom_ent;
  logic [7:0] rom_val;
  logic       id_lock_slot;
  logic       q_lock_slot;
  logic       q_hole;
  logic       id_far;

  // identifier mode repeats every 4 entries, query mode every 64
  always_comb begin
    rom_ent = (mode == MODE_IDENT) ? {4'd0, low7[1:0]} : low7[5:0];
  end

  fr_cap_rom u_rom (
    .ent (rom_ent),
    .val (rom_val)
  );

  always_comb begin
    id_lock_slot = (low7[1:0] == LOCK_SLOT);
    q_lock_slot  = (low7 == {5'd0, LOCK_SLOT});
    q_hole       = (low7[6:4] == 3'b100);
    id_far       = (low7[4:2] != 3'd0);
  end

  always_comb begin
    case (mode)
      MODE_ARRAY: sel_data = arr_data;
      MODE_IDENT: begin
        if (id_lock_slot) sel_data = {6'd0, id_far, lock_bit};
        else              sel_data = rom_val;
      end
      MODE_QUERY: begin
        if (q_lock_slot)  sel_data = {7'd0, lock_bit};
        else if (q_hole)  sel_data = 8'h00;
        else              sel_data = rom_val;
      end
      MODE_STAT:  sel_data = status;
      MODE_XSTAT: sel_data = ext_status;
      default:    sel_data = 8'h00;
    endcase
  end
endmodule

// File: rtl/flash_id_read_mux.sv
module flash_id_read_mux #(
  parameter int ADDR_W    = 21,
  parameter int BLK_SHIFT = 15,
  localparam int IDX_W    = ADDR_W - 1,
  localparam int BLK_W    = IDX_W - BLK_SHIFT,
  localparam int NBLK     = 1 << BLK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        rd_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        status,
  input  logic [7:0]        ext_status,
  input  logic [NBLK-1:0]   lock_bits,
  input  logic [7:0]        arr_data,
  output logic [IDX_W-1:0]  arr_idx,
  output logic [7:0]        rd_data
);
  import fr_pkg::*;

  logic [IDX_W-1:0] idx;
  logic [BLK_W-1:0] blk;
  logic             lock_bit;
  logic [7:0]       rd_next;
  logic [7:0]       rd_q;

  always_comb begin
    idx      = addr[ADDR_W-1:1];
    blk      = idx[IDX_W-1:BLK_SHIFT];
    lock_bit = lock_bits[blk];
    arr_idx  = idx;
  end

  fr_fold u_fold (
    .mode       (rd_mode),
    .low7       (idx[6:0]),
    .lock_bit   (lock_bit),
    .status     (status),
    .ext_status (ext_status),
    .arr_data   (arr_data),
    .sel_data   (rd_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= 8'h00;
    else        rd_q <= rd_next;
  end

  assign rd_data = rd_q;

  a_r3_array_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode == MODE_ARRAY) |=> (rd_data == $past(arr_data)));

  a_r9_status_any_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode == MODE_STAT) |=> (rd_data == $past(status)));

  a_r10_xstatus_any_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode == MODE_XSTAT) |=> (rd_data == $past(ext_status)));

  a_r7_query_hole_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode == MODE_QUERY && addr[7:5] == 3'b100) |=> (rd_data == 8'h00));

  a_r5_ident_lock_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode == MODE_IDENT && addr[2:1] == 2'd2) |=>
      (rd_data[7:2] == 6'd0 && rd_data[0] == $past(lock_bit)));

  a_r11_unused_mode_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode > MODE_XSTAT) |=> (rd_data == 8'h00));
endmodule

// File: tb/tb_flash_id_read_mux.sv
`timescale 1ns/1ps
module tb_flash_id_read_mux;
  localparam int ADDR_W = 21;
  localparam int IDX_W  = ADDR_W - 1;
  localparam int NBLK   = 32;

  logic              clk;
  logic              rst_n;
  logic [2:0]        rd_mode;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        status;
  logic [7:0]        ext_status;
  logic [NBLK-1:0]   lock_bits;
  logic [7:0]        arr_data;
  logic [IDX_W-1:0]  arr_idx;
  logic [7:0]        rd_data;

  int checks;
  int failures;
  bit done;

  flash_id_read_mux dut (
    .clk(clk), .rst_n(rst_n), .rd_mode(rd_mode), .addr(addr),
    .status(status), .ext_status(ext_status), .lock_bits(lock_bits),
    .arr_data(arr_data), .arr_idx(arr_idx), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] tbl(input int e);
    case (e)
      'h00: return 8'hB0; 'h01: return 8'hD0; 'h03: return 8'h02;
      'h10: return 8'h51; 'h11: return 8'h52; 'h12: return 8'h59;
      'h13: return 8'h01; 'h15: return 8'h31;
      'h1B: return 8'h30; 'h1C: return 8'h55; 'h1D: return 8'h30;
      'h1E: return 8'h55; 'h1F: return 8'h03; 'h20: return 8'h06;
      'h21: return 8'h0A; 'h22: return 8'h0F;
      'h23, 'h24, 'h25, 'h26: return 8'h04;
      'h27: return 8'h15; 'h28: return 8'h02; 'h2A: return 8'h05;
      'h2C: return 8'h01; 'h2D: return 8'h1F; 'h30: return 8'h01;
      'h31: return 8'h50; 'h32: return 8'h52; 'h33: return 8'h49;
      'h34: return 8'h31; 'h35: return 8'h30; 'h36: return 8'h0F;
      'h3A: return 8'h01; 'h3B: return 8'h03;
      'h3D: return 8'h50; 'h3E: return 8'h50;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] model(input logic [2:0] m, input int ix,
                                       input logic [7:0] st, input logic [7:0] xs,
                                       input logic [NBLK-1:0] lk, input logic [7:0] ad);
    logic lb;
    int   q;
    lb = lk[ix >> 15];
    q  = ix & 'h7F;
    case (m)
      3'd0: return ad;
      3'd1: begin
        if ((ix & 3) != 2) return tbl(ix & 3);
        return {6'd0, ((ix & 'h1F) >= 4), lb};
      end
      3'd2: begin
        if (q == 2) return {7'd0, lb};
        if (q >= 'h40 && q < 'h50) return 8'h00;
        return tbl(ix & 'h3F);
      end
      3'd3: return st;
      3'd4: return xs;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] m, input int ix);
    int q;
    q = ix & 'h7F;
    case (m)
      3'd0: return "R3";
      3'd1: return ((ix & 3) == 2) ? "R5" : "R4";
      3'd2: begin
        if (q == 2) return "R6";
        if (q >= 'h40 && q < 'h50) return "R7";
        return "R8";
      end
      3'd3: return "R9";
      3'd4: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] m, input int ix);
    logic [7:0] e;
    @(negedge clk);
    rd_mode    = m;
    addr       = {ix[IDX_W-1:0], 1'($urandom)};
    status     = 8'($urandom);
    ext_status = 8'($urandom);
    lock_bits  = $urandom;
    arr_data   = 8'($urandom);
    e = model(m, ix, status, ext_status, lock_bits, arr_data);
    #1;
    check("R2", 32'(arr_idx), 32'(ix[IDX_W-1:0]));
    @(negedge clk);
    check(req_of(m, ix), 32'(rd_data), 32'(e));
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    checks = 0; failures = 0; done = 1'b0;
    void'($urandom(32'h1A2B3C4D));
    rst_n = 1'b0; rd_mode = 3'd3; addr = '0;
    status = 8'hA5; ext_status = 8'h80; lock_bits = '0; arr_data = 8'h11;
    repeat (3) @(negedge clk);
    check("R1", 32'(rd_data), 32'h00);
    rst_n = 1'b1;
    #1;
    check("R1", 32'(rd_data), 32'h00);
    @(negedge clk);
    check("R9", 32'(rd_data), 32'hA5);
    // R2: output holds until the next edge
    held = rd_data;
    status = 8'h3C;
    #1;
    check("R2", 32'(rd_data), 32'(held));
    @(negedge clk);
    check("R2", 32'(rd_data), 32'h3C);

    // R4 identifier codes and repetition
    apply(3'd1, 'h0); apply(3'd1, 'h1); apply(3'd1, 'h3);
    apply(3'd1, 'h4); apply(3'd1, 'h7FFD);
    // R5 lock slot with and without bit 1
    apply(3'd1, 'h2); apply(3'd1, 'h6); apply(3'd1, 'h22);
    apply(3'd1, (3 << 15) | 'h2); apply(3'd1, (31 << 15) | 'h1E);
    // R6 query lock slot
    apply(3'd2, 'h2); apply(3'd2, 'h82); apply(3'd2, (17 << 15) | 'h102);
    // R7 hole edges
    apply(3'd2, 'h40); apply(3'd2, 'h42); apply(3'd2, 'h4F); apply(3'd2, 'hC5);
    // R8 named table entries and fold
    for (int i = 'h10; i <= 'h12; i++) apply(3'd2, i);
    apply(3'd2, 'h2A);
    for (int i = 'h2D; i <= 'h33; i++) apply(3'd2, i);
    apply(3'd2, 'h50); apply(3'd2, 'h3F); apply(3'd2, 'h7F);
    // R3, R9, R10, R11
    apply(3'd0, 'h12345); apply(3'd3, 'hFFFFF); apply(3'd4, 'h2);
    apply(3'd5, 'h2); apply(3'd6, 'h10); apply(3'd7, 'h0);

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      logic [2:0] m;
      int ix;
      m  = 3'($urandom_range(0, 7));
      ix = int'($urandom) & 'hFFFFF;
      case ($urandom_range(0, 3))
        0: ix = (ix & ~'h3) | 'h2;
        1: ix = (ix & ~'h7F) | 'h40 | (ix & 'hF);
        default: ;
      endcase
      apply(m, ix);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule